// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a four-bank, 32-bit DDR SDRAM. It brings the memory from power-on to an idle, programmed state. After reset it keeps clock enable low and deselects the device. It then waits out a stable-clock period and raises clock enable. After that it issues a fixed command sequence:

- precharge all banks;
- extended mode register write, which enables the DLL and sets drive strength;
- mode register write with DLL reset;
- a second precharge all;
- two auto-refreshes;
- a final mode register write without DLL reset.

Every wait is a cycle count. Each count is derived at elaboration from nanosecond figures and the clock period, both of which are parameters.

Between commands the sequencer drives NOPs. It raises `init_done` only when two conditions hold: the final mode register write has had its settle time, and the DLL has had its lock window counted from the DLL-reset write. After that the pins stay at NOP, and the memory controller that owns the bus takes over.

Top module: `ddr_init_seq`

## Requirements
- R1: From reset, `ddr_cke` is low and `ddr_cs_n` is high (deselect) for STABLE_NS converted to clocks (rounded up) of cycles after reset release, give or take one. Once `ddr_cke` rises it never falls again.
- R2: The first command is issued exactly one clock after `ddr_cke` rises, and that clock carries a NOP.
- R3: Exactly seven commands are issued, in this order: precharge-all, extended mode write, mode write with DLL reset, precharge-all, refresh, refresh, mode write without DLL reset.
- R4: Precharge-all drives {cs_n,ras_n,cas_n,we_n} = 0010, and `ddr_addr[8]` = 1.
- R5: The extended mode write drives {cs_n,ras_n,cas_n,we_n} = 0000 with `ddr_ba` = 01. Its address is all zero except bit 1, which carries the drive-strength parameter; bit 0 = 0 means the DLL is enabled.
- R6: A mode write drives 0000 with `ddr_ba` = 00. Its address is BL_CODE in bits 2:0, BURST_IL in bit 3, CL_CODE in bits 6:4 and 0 in bit 7, with the DLL reset flag in bit 8. The flag is 1 on the first mode write and 0 on the last. All higher bits are zero.
- R7: A refresh is {cs_n,ras_n,cas_n,we_n} = 0001. Spacing from one command to the next is as follows:
  - after a precharge: ceil(TRP_NS/period) clocks;
  - after a refresh: ceil(TRFC_NS/period) clocks;
  - after a mode write: TMRD_CLKS clocks.
- R8: Every cycle between the rise of `ddr_cke` and `init_done` that carries no command is a NOP, {cs_n,ras_n,cas_n,we_n} = 0111.
- R9: Let D be the cycle of the DLL-reset mode write and F the cycle of the final mode write. `init_done` rises on the cycle after the later of D+LOCK_CLKS and F+TMRD_CLKS.
- R10: Once `init_done` is high it stays high, and the pins stay at NOP with `ddr_cke` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ddr_cke | output | 1 | Memory clock enable |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | 2 | Bank address / mode register select |
| ddr_addr | output | ADDR_W | Address bus / mode word |
| init_done | output | 1 | Initialization finished |

## Verification
Two conditions can expire in the same cycle: the end of the settle gap after the last mode write, and the end of the DLL lock window. The bench provokes this with a second instance whose lock window is set to exactly 41 clocks, which is the offset from the DLL-reset write to the end of the final settle gap at a 5 ns clock. The default instance keeps the lock window as the later of the two. In both instances the bench computes the expected rise of `init_done` as one cycle past the later of the two expiries, and compares it against the observed cycle.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

   typedef enum logic [2:0] {
      CMD_DESEL,
      CMD_NOP,
      CMD_PREA,
      CMD_EMRS,
      CMD_MRS_DLLRST,
      CMD_REF,
      CMD_MRS
   } ddr_cmd_e;

   typedef enum logic [2:0] {
      ST_WAIT,
      ST_CKE,
      ST_CMD,
      ST_GAP,
      ST_LOCK,
      ST_DONE
   } seq_state_e;

   // Round a nanosecond figure up to whole clocks, never less than one.
   function automatic int ns_to_clks(input int ns, input int clk_ps);
      int c;
      c = (ns * 1000 + clk_ps - 1) / clk_ps;
      return (c < 1) ? 1 : c;
   endfunction

endpackage

// File: rtl/ddr_init_cnt.sv
module ddr_init_cnt #(
   parameter int W       = 8,
   parameter int RST_VAL = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec_en,
   output logic         zero
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= W'(RST_VAL);
      else if (load)
         cnt_q <= load_val;
      else if (dec_en && (cnt_q != '0))
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

   AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (zero && !load) |=> zero) else $error("counter wrapped"); // R7

endmodule

// File: rtl/ddr_init_enc.sv
module ddr_init_enc
   import ddr_init_pkg::*;
#(
   parameter int         ADDR_W   = 12,
   parameter int         AP_BIT   = 8,
   parameter logic [2:0] BL_CODE  = 3'd1,
   parameter logic       BURST_IL = 1'b0,
   parameter logic [2:0] CL_CODE  = 3'd3,
   parameter logic       DRV_WEAK = 1'b0
) (
   input  ddr_cmd_e          cmd,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [1:0]        ba,
   output logic [ADDR_W-1:0] addr
);

   localparam int MODE_BITS = 9;

   // Mode word: burst length, burst type, CAS latency, test mode off.
   localparam logic [MODE_BITS-1:0] MR_BASE =
      {1'b0, 1'b0, CL_CODE, BURST_IL, BL_CODE};
   localparam logic [MODE_BITS-1:0] EMR_WORD =
      {7'd0, DRV_WEAK, 1'b0};

   generate
      if (ADDR_W < MODE_BITS) begin : g_bad_width
         $error("ADDR_W too narrow for the mode word");
      end
      if (AP_BIT >= ADDR_W) begin : g_bad_ap
         $error("AP_BIT outside the address bus");
      end
   endgenerate

   always_comb begin
      cs_n  = 1'b0;
      ras_n = 1'b1;
      cas_n = 1'b1;
      we_n  = 1'b1;
      ba    = 2'b00;
      addr  = '0;
      unique case (cmd)
         CMD_DESEL: cs_n = 1'b1;
         CMD_NOP: ;
         CMD_PREA: begin
            ras_n        = 1'b0;
            we_n         = 1'b0;
            addr[AP_BIT] = 1'b1;
         end
         CMD_REF: begin
            ras_n = 1'b0;
            cas_n = 1'b0;
         end
         CMD_EMRS: begin
            ras_n = 1'b0;
            cas_n = 1'b0;
            we_n  = 1'b0;
            ba    = 2'b01;
            addr  = ADDR_W'(EMR_WORD);
         end
         CMD_MRS_DLLRST, CMD_MRS: begin
            ras_n   = 1'b0;
            cas_n   = 1'b0;
            we_n    = 1'b0;
            addr    = ADDR_W'(MR_BASE);
            addr[8] = (cmd == CMD_MRS_DLLRST);
         end
         default: cs_n = 1'b1;
      endcase
   end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
   import ddr_init_pkg::*;
#(
   parameter int         CLK_PS    = 5000,
   parameter int         STABLE_NS = 200000,
   parameter int         TRP_NS    = 22,
   parameter int         TRFC_NS   = 77,
   parameter int         TMRD_CLKS = 2,
   parameter int         LOCK_CLKS = 200,
   parameter int         N_REF     = 2,
   parameter int         ADDR_W    = 12,
   parameter int         AP_BIT    = 8,
   parameter logic [2:0] BL_CODE   = 3'd1,
   parameter logic       BURST_IL  = 1'b0,
   parameter logic [2:0] CL_CODE   = 3'd3,
   parameter logic       DRV_WEAK  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              ddr_cke,
   output logic              ddr_cs_n,
   output logic              ddr_ras_n,
   output logic              ddr_cas_n,
   output logic              ddr_we_n,
   output logic [1:0]        ddr_ba,
   output logic [ADDR_W-1:0] ddr_addr,
   output logic              init_done
);

   localparam int STABLE_CLKS = ns_to_clks(STABLE_NS, CLK_PS);
   localparam int GAP_TRP     = ns_to_clks(TRP_NS, CLK_PS);
   localparam int GAP_TRFC    = ns_to_clks(TRFC_NS, CLK_PS);
   localparam int GAP_MAX     = (GAP_TRFC > GAP_TRP) ?
                                ((GAP_TRFC > TMRD_CLKS) ? GAP_TRFC : TMRD_CLKS) :
                                ((GAP_TRP > TMRD_CLKS) ? GAP_TRP : TMRD_CLKS);
   localparam int WAIT_W      = $clog2(STABLE_CLKS + 1);
   localparam int GAP_W       = $clog2(GAP_MAX + 1);
   localparam int LOCK_W      = $clog2(LOCK_CLKS + 1);
   localparam int LAST_STEP   = 4 + N_REF;
   localparam int STEP_W      = $clog2(LAST_STEP + 1);

   generate
      if (N_REF < 2) begin : g_bad_ref
         $error("at least two refreshes are required");
      end
      if (LOCK_CLKS < 2) begin : g_bad_lock
         $error("LOCK_CLKS must be at least 2");
      end
      if (TMRD_CLKS < 1) begin : g_bad_tmrd
         $error("TMRD_CLKS must be at least 1");
      end
   endgenerate

   seq_state_e        state_q;
   logic [STEP_W-1:0] step_q;
   ddr_cmd_e          cur_cmd, pin_cmd;
   int                cur_gap;
   logic              wait_zero, gap_zero, lock_zero;
   logic              last_step;

   always_comb begin
      if (step_q == STEP_W'(0) || step_q == STEP_W'(3))
         cur_cmd = CMD_PREA;
      else if (step_q == STEP_W'(1))
         cur_cmd = CMD_EMRS;
      else if (step_q == STEP_W'(2))
         cur_cmd = CMD_MRS_DLLRST;
      else if (step_q == STEP_W'(LAST_STEP))
         cur_cmd = CMD_MRS;
      else
         cur_cmd = CMD_REF;
   end

   always_comb begin
      unique case (cur_cmd)
         CMD_PREA: cur_gap = GAP_TRP;
         CMD_REF:  cur_gap = GAP_TRFC;
         default:  cur_gap = TMRD_CLKS;
      endcase
   end

   assign last_step = (step_q == STEP_W'(LAST_STEP));

   ddr_init_cnt #(.W(WAIT_W), .RST_VAL(STABLE_CLKS - 1)) u_wait (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (1'b0),
      .load_val ('0),
      .dec_en   (state_q == ST_WAIT),
      .zero     (wait_zero)
   );

   ddr_init_cnt #(.W(GAP_W), .RST_VAL(0)) u_gap (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (state_q == ST_CMD),
      .load_val ((cur_gap >= 2) ? GAP_W'(cur_gap - 2) : '0),
      .dec_en   (state_q == ST_GAP),
      .zero     (gap_zero)
   );

   ddr_init_cnt #(.W(LOCK_W), .RST_VAL(0)) u_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     ((state_q == ST_CMD) && (cur_cmd == CMD_MRS_DLLRST)),
      .load_val (LOCK_W'(LOCK_CLKS - 1)),
      .dec_en   (1'b1),
      .zero     (lock_zero)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_WAIT;
         step_q  <= '0;
      end else begin
         unique case (state_q)
            ST_WAIT: if (wait_zero) state_q <= ST_CKE;
            ST_CKE:  state_q <= ST_CMD;
            ST_CMD, ST_GAP: begin
               if ((state_q == ST_CMD && cur_gap <= 1) ||
                   (state_q == ST_GAP && gap_zero)) begin
                  if (last_step) begin
                     state_q <= ST_LOCK;
                  end else begin
                     step_q  <= step_q + 1'b1;
                     state_q <= ST_CMD;
                  end
               end else if (state_q == ST_CMD) begin
                  state_q <= ST_GAP;
               end
            end
            ST_LOCK: if (lock_zero) state_q <= ST_DONE;
            ST_DONE: ;
            default: state_q <= ST_WAIT;
         endcase
      end
   end

   always_comb begin
      unique case (state_q)
         ST_WAIT: pin_cmd = CMD_DESEL;
         ST_CMD:  pin_cmd = cur_cmd;
         default: pin_cmd = CMD_NOP;
      endcase
   end

   assign ddr_cke   = (state_q != ST_WAIT);
   assign init_done = (state_q == ST_DONE);

   ddr_init_enc #(
      .ADDR_W   (ADDR_W),
      .AP_BIT   (AP_BIT),
      .BL_CODE  (BL_CODE),
      .BURST_IL (BURST_IL),
      .CL_CODE  (CL_CODE),
      .DRV_WEAK (DRV_WEAK)
   ) u_enc (
      .cmd   (pin_cmd),
      .cs_n  (ddr_cs_n),
      .ras_n (ddr_ras_n),
      .cas_n (ddr_cas_n),
      .we_n  (ddr_we_n),
      .ba    (ddr_ba),
      .addr  (ddr_addr)
   );

   AST_CKE_NEVER_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
      ddr_cke |=> ddr_cke) else $error("cke fell"); // R1
   AST_DESEL_WHILE_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !ddr_cke |-> ddr_cs_n) else $error("command with cke low"); // R1
   AST_GAP_IS_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_GAP) |-> (!ddr_cs_n && ddr_ras_n && ddr_cas_n && ddr_we_n))
      else $error("non-NOP inside a gap"); // R8
   AST_PREA_AP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (!ddr_cs_n && !ddr_ras_n && ddr_cas_n && !ddr_we_n) |-> ddr_addr[AP_BIT])
      else $error("precharge without AP"); // R4
   AST_DONE_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_done) |-> lock_zero) else $error("done before DLL lock"); // R9
   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done) else $error("done dropped"); // R10
   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |-> (ddr_cke && !ddr_cs_n && ddr_ras_n && ddr_cas_n && ddr_we_n))
      else $error("activity after done"); // R10

endmodule

// File: tb/ddr_init_mon.sv
module ddr_init_mon #(
   parameter int STABLE_CLKS = 40000,
   parameter int GAP_PRE     = 5,
   parameter int GAP_REF     = 16,
   parameter int GAP_MR      = 2,
   parameter int LOCK        = 200,
   parameter int MR_BASE     = 'h31,
   parameter int EMR_WORD    = 0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cke,
   input  logic        cs_n,
   input  logic        ras_n,
   input  logic        cas_n,
   input  logic        we_n,
   input  logic [1:0]  ba,
   input  logic [11:0] addr,
   input  logic        done,
   output int          n_chk,
   output int          n_bad,
   output logic        finished
);

   int   cyc = 0, low_cnt = 0, cke_cyc = 0, last_cyc = 0;
   int   idx = 0, d_cyc = 0, f_cyc = 0, after = 0;
   logic rst_seen = 0, cke_seen = 0, done_seen = 0;

   initial begin
      n_chk = 0; n_bad = 0; finished = 0;
   end

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   function automatic int exp_code(input int i);
      case (i)
         0, 3: return 1;
         1: return 2;
         2: return 3;
         4, 5: return 4;
         default: return 5;
      endcase
   endfunction

   function automatic int gap_of(input int code);
      case (code)
         1: return GAP_PRE;
         4: return GAP_REF;
         default: return GAP_MR;
      endcase
   endfunction

   always @(negedge clk) begin
      int code, mx;
      if (!rst_n) begin
         if (!rst_seen) begin
            rst_seen = 1;
            chk(cke == 0, "R1 reset cke", cke, 0);
            chk(done == 0, "R9 reset done", done, 0);
         end
      end else if (!finished) begin
         cyc++;
         if (!cke) begin
            low_cnt++;
            if (!cs_n) chk(0, "R1 deselect while cke low", cs_n, 1);
            if (cke_seen) chk(0, "R1 cke fell", cke, 1);
         end else if (!cke_seen) begin
            cke_seen = 1;
            cke_cyc  = cyc;
            chk(low_cnt >= STABLE_CLKS && low_cnt <= STABLE_CLKS + 1,
                "R1 stable wait length", low_cnt, STABLE_CLKS);
         end
         if (cke_seen && !cs_n && !(ras_n && cas_n && we_n)) begin
            code = 9;
            if (!ras_n && cas_n && !we_n) code = 1;
            else if (!ras_n && !cas_n && we_n) code = 4;
            else if (!ras_n && !cas_n && !we_n)
               code = (ba == 2'b01) ? 2 : ((ba == 2'b00) ? (addr[8] ? 3 : 5) : 9);
            chk(idx < 7, "R3 command count", idx + 1, 7);
            chk(code == exp_code(idx), "R3 command order", code, exp_code(idx));
            if (idx == 0)
               chk(cyc - cke_cyc == 1, "R2 cke-to-first-command", cyc - cke_cyc, 1);
            else
               chk(cyc - last_cyc == gap_of(exp_code(idx - 1)), "R7 spacing",
                   cyc - last_cyc, gap_of(exp_code(idx - 1)));
            if (code == 1) chk(addr[8] == 1'b1, "R4 precharge AP", addr[8], 1);
            if (code == 2) chk(int'(addr) == EMR_WORD, "R5 ext mode word", addr, EMR_WORD);
            if (code == 3) chk(int'(addr) == (MR_BASE | 'h100), "R6 mode word DLL reset",
                               addr, MR_BASE | 'h100);
            if (code == 5) chk(int'(addr) == MR_BASE, "R6 final mode word", addr, MR_BASE);
            if (idx == 2) d_cyc = cyc;
            if (idx == 6) f_cyc = cyc;
            last_cyc = cyc;
            idx++;
         end else if (cke_seen && !done_seen) begin
            chk(!cs_n && ras_n && cas_n && we_n, "R8 NOP between commands",
                {cs_n, ras_n, cas_n, we_n}, 7);
         end
         if (done && !done_seen) begin
            done_seen = 1;
            mx = (d_cyc + LOCK > f_cyc + GAP_MR) ? d_cyc + LOCK : f_cyc + GAP_MR;
            chk(idx == 7, "R9 all commands before done", idx, 7);
            chk(cyc == mx + 1, "R9 done cycle", cyc - d_cyc, mx + 1 - d_cyc);
         end else if (!done && !done_seen && idx == 7 && cyc > d_cyc + LOCK + 400) begin
            chk(0, "R9 done never rose", 0, 1);
            finished = 1;
         end else if (done_seen) begin
            after++;
            chk(done && cke && !cs_n && ras_n && cas_n && we_n, "R10 idle after done",
                {done, cke, cs_n, ras_n, cas_n, we_n}, 'h27);
            if (after == 20) finished = 1;
         end
         if (!done && done_seen) begin
            chk(0, "R10 done dropped", 0, 1);
            finished = 1;
         end
      end
   end

endmodule

// File: tb/tb_ddr_init_seq.sv
module tb_ddr_init_seq;

   localparam int CLK_PS = 5000;

   logic clk = 0;
   logic rst_n = 0;
   always #2.5 clk = ~clk;

   logic        cke_a, cs_a, ras_a, cas_a, we_a, done_a;
   logic [1:0]  ba_a;
   logic [11:0] addr_a;
   logic        cke_b, cs_b, ras_b, cas_b, we_b, done_b;
   logic [1:0]  ba_b;
   logic [11:0] addr_b;
   int          chk_a, bad_a, chk_b, bad_b;
   logic        fin_a, fin_b;

   // Default instance: lock window outlasts the final settle gap.
   ddr_init_seq #(.CLK_PS(CLK_PS), .DRV_WEAK(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .ddr_cke(cke_a), .ddr_cs_n(cs_a),
      .ddr_ras_n(ras_a), .ddr_cas_n(cas_a), .ddr_we_n(we_a),
      .ddr_ba(ba_a), .ddr_addr(addr_a), .init_done(done_a));

   // Second instance: lock window ends on the same cycle as the last gap.
   ddr_init_seq #(.CLK_PS(CLK_PS), .STABLE_NS(1000), .LOCK_CLKS(41),
                  .BL_CODE(3'd2), .BURST_IL(1'b1), .CL_CODE(3'd2)) dut_tie (
      .clk(clk), .rst_n(rst_n), .ddr_cke(cke_b), .ddr_cs_n(cs_b),
      .ddr_ras_n(ras_b), .ddr_cas_n(cas_b), .ddr_we_n(we_b),
      .ddr_ba(ba_b), .ddr_addr(addr_b), .init_done(done_b));

   // Expected figures worked out arithmetically: ceil(ns*1000/ps).
   ddr_init_mon #(
      .STABLE_CLKS((200000 * 1000 + CLK_PS - 1) / CLK_PS),
      .GAP_PRE((22 * 1000 + CLK_PS - 1) / CLK_PS),
      .GAP_REF((77 * 1000 + CLK_PS - 1) / CLK_PS),
      .GAP_MR(2), .LOCK(200),
      .MR_BASE(1 | (0 << 3) | (3 << 4)), .EMR_WORD(1 << 1)
   ) mon_a (
      .clk(clk), .rst_n(rst_n), .cke(cke_a), .cs_n(cs_a), .ras_n(ras_a),
      .cas_n(cas_a), .we_n(we_a), .ba(ba_a), .addr(addr_a), .done(done_a),
      .n_chk(chk_a), .n_bad(bad_a), .finished(fin_a));

   ddr_init_mon #(
      .STABLE_CLKS((1000 * 1000 + CLK_PS - 1) / CLK_PS),
      .GAP_PRE((22 * 1000 + CLK_PS - 1) / CLK_PS),
      .GAP_REF((77 * 1000 + CLK_PS - 1) / CLK_PS),
      .GAP_MR(2), .LOCK(41),
      .MR_BASE(2 | (1 << 3) | (2 << 4)), .EMR_WORD(0)
   ) mon_b (
      .clk(clk), .rst_n(rst_n), .cke(cke_b), .cs_n(cs_b), .ras_n(ras_b),
      .cas_n(cas_b), .we_n(we_b), .ba(ba_b), .addr(addr_b), .done(done_b),
      .n_chk(chk_b), .n_bad(bad_b), .finished(fin_b));

   initial begin
      int extra_bad;
      extra_bad = 0;
      repeat (4) @(negedge clk);
      rst_n = 1;
      for (int i = 0; i < 100000; i++) begin
         @(negedge clk);
         if (fin_a && fin_b) break;
      end
      #1;
      if (!(fin_a && fin_b)) begin
         extra_bad = 1;
         $display("FAIL R9 watchdog expired actual=%0d expected=%0d",
                  {fin_a, fin_b}, 3);
      end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***",
               chk_a + chk_b + extra_bad, bad_a + bad_b + extra_bad);
      $finish;
   end

endmodule